// File: doc/BRIEF.md
# Request Priority Escalation Timer

This block sits beside a pending bus request that is waiting for service from the memory controllers. It measures how many clock cycles the request has been outstanding. Once that wait reaches a programmable threshold, it raises a high-priority request so the controllers can favour the starved requester. A grant, or the request being withdrawn, retires the wait, and the next request is timed from zero.

The threshold is an 8-bit value held in a register that can be read and written. A threshold of zero turns escalation off. The threshold can be changed while a request is waiting. The new value is used from the next comparison, so a threshold lowered below the wait already elapsed escalates at once. Once a request has escalated, it stays escalated until it is granted or withdrawn. The wait counter stops at its maximum and does not wrap, so a very long wait cannot lose its escalation.

Top module: `req_escalate_timer`

## Requirements
- R1: The threshold register resets to 0x40. `thr_rd_data` always shows the stored threshold. A write with `thr_wr_en` high stores `thr_wr_data` at that clock edge, so the new value is visible from the next cycle.
- R2: With a nonzero threshold T, and `req_valid` held high with no grant, `hipri_req` is low until T rising edges have passed with the request pending. It goes high from the cycle after the T-th edge.
- R3: With a threshold of zero, a request that is not already escalated never asserts `hipri_req`, however long it waits.
- R4: A cycle with `req_valid` low clears the wait count. A new request is timed from scratch, and `hipri_req` is low in the cycle after the withdrawal.
- R5: An edge with `req_grant` high clears the wait count and the escalation. `hipri_req` is low in the following cycle, and a request still held is then timed again from zero. A grant with no request pending has no effect on later timing.
- R6: Once `hipri_req` is high, it stays high while `req_valid` stays high and no grant arrives. This holds even if the threshold is rewritten to a larger value or to zero.
- R7: If the threshold is written, while a request is pending, to a nonzero value at or below the edges already elapsed, `hipri_req` goes high in the cycle right after the write edge.
- R8: The wait count saturates. With threshold 255, a request held for 300 cycles is escalated from edge 255 to the end of the wait without dropping.
- R9: `hipri_req` is low in every cycle in which `req_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| thr_wr_en | input | 1 | Threshold write strobe |
| thr_wr_data | input | 8 | Threshold value to write |
| thr_rd_data | output | 8 | Current threshold value |
| req_valid | input | 1 | Bus request pending |
| req_grant | input | 1 | Request retired by the controllers |
| hipri_req | output | 1 | High-priority request to the memory controllers |

## Verification
The bench builds the block with its default 8-bit threshold and 8-bit counter. At that width every threshold from 0 to 255 can be swept. For each one, the exact escalation cycle and readback are checked, and so is the moment where the counter reaches its ceiling and must hold rather than wrap. The same width keeps the longest single wait short enough that further directed runs fit easily: withdrawal, grant, threshold changes in mid-count and a 300-cycle saturation hold.

// File: rtl/esc_pkg.sv
// Package: shared defaults and helpers for the escalation timer.
// Assumes threshold and wait counter share one width.
package esc_pkg;
    localparam int THR_W_DEF = 8;
    localparam int THR_RST_DEF = 8'h40;
endpackage

// File: rtl/esc_thr_reg.sv
// Threshold register: holds the escalation threshold and accepts writes.
// Assumes a single writer; the write lands at the strobed edge.
module esc_thr_reg #(
    parameter int THR_W   = esc_pkg::THR_W_DEF,
    parameter int THR_RST = esc_pkg::THR_RST_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [THR_W-1:0] wr_data,
    output logic [THR_W-1:0] thr
);
    localparam logic [THR_W-1:0] RST_VAL = THR_W'(THR_RST);

    // Store the threshold on reset or on a write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            thr <= RST_VAL;
        else if (wr_en)
            thr <= wr_data;
    end
endmodule

// File: rtl/esc_wait_ctr.sv
// Wait counter: counts edges while the request is pending and stops at its maximum.
// Assumes run is low whenever the request is absent or granted.
module esc_wait_ctr #(
    parameter int CNT_W = esc_pkg::THR_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // Clear when idle, otherwise advance until the ceiling.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            cnt <= '0;
        else if (cnt != CNT_MAX)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/esc_flag.sv
// Escalation flag: compares the wait with the threshold and keeps the result sticky.
// Assumes cnt is cleared by the same run condition that clears the flag.
module esc_flag #(
    parameter int THR_W = esc_pkg::THR_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             req_valid,
    input  logic [THR_W-1:0] cnt,
    input  logic [THR_W-1:0] thr,
    output logic             hipri
);
    logic hit;
    logic esc_q;

    // Threshold reached; zero threshold never matches.
    always_comb hit = (thr != '0) && (cnt >= thr);

    // Remember escalation until the request is retired.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            esc_q <= 1'b0;
        else if (hit)
            esc_q <= 1'b1;
    end

    // Drive the output only while the request is present.
    always_comb hipri = req_valid && (esc_q || hit);
endmodule

// File: rtl/req_escalate_timer.sv
// Top: times a pending bus request and raises a high-priority request
// once the wait reaches the programmed threshold (zero disables).
// Assumes req_valid stays high until granted or withdrawn.
module req_escalate_timer #(
    parameter int THR_W   = esc_pkg::THR_W_DEF,
    parameter int THR_RST = esc_pkg::THR_RST_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             thr_wr_en,
    input  logic [THR_W-1:0] thr_wr_data,
    output logic [THR_W-1:0] thr_rd_data,
    input  logic             req_valid,
    input  logic             req_grant,
    output logic             hipri_req
);
    logic             run;
    logic [THR_W-1:0] thr;
    logic [THR_W-1:0] cnt;

    // Timing runs only for a pending, ungranted request.
    always_comb run = req_valid && !req_grant;

    esc_thr_reg #(.THR_W(THR_W), .THR_RST(THR_RST)) thr_i (
        .clk(clk), .rst_n(rst_n), .wr_en(thr_wr_en),
        .wr_data(thr_wr_data), .thr(thr)
    );

    esc_wait_ctr #(.CNT_W(THR_W)) ctr_i (
        .clk(clk), .rst_n(rst_n), .run(run), .cnt(cnt)
    );

    esc_flag #(.THR_W(THR_W)) flag_i (
        .clk(clk), .rst_n(rst_n), .run(run), .req_valid(req_valid),
        .cnt(cnt), .thr(thr), .hipri(hipri_req)
    );

    // Expose the stored threshold.
    always_comb thr_rd_data = thr;
endmodule

// File: rtl/req_escalate_timer_chk.sv
// Checker: port-level properties of the escalation timer, bound to the top.
module req_escalate_timer_chk #(
    parameter int THR_W = esc_pkg::THR_W_DEF
) (
    input logic             clk,
    input logic             rst_n,
    input logic             thr_wr_en,
    input logic [THR_W-1:0] thr_wr_data,
    input logic [THR_W-1:0] thr_rd_data,
    input logic             req_valid,
    input logic             req_grant,
    input logic             hipri_req
);
    AST_THR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        thr_wr_en |=> thr_rd_data == $past(thr_wr_data)); // R1
    AST_ZERO_THR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_rd_data == '0) && !hipri_req && !thr_wr_en |=> !hipri_req); // R3
    AST_DROP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !hipri_req); // R4
    AST_GRANT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        req_grant |=> !hipri_req); // R5
    AST_STICKY_ESC: assert property (@(posedge clk) disable iff (!rst_n)
        hipri_req && !req_grant |=> !req_valid || hipri_req); // R6
    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> !hipri_req); // R9
endmodule

bind req_escalate_timer req_escalate_timer_chk #(.THR_W(THR_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .thr_wr_en(thr_wr_en), .thr_wr_data(thr_wr_data),
    .thr_rd_data(thr_rd_data), .req_valid(req_valid), .req_grant(req_grant),
    .hipri_req(hipri_req)
);

// File: tb/req_escalate_timer_tb_top.sv
module req_escalate_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       thr_wr_en = 1'b0;
    logic [7:0] thr_wr_data = '0;
    logic [7:0] thr_rd_data;
    logic       req_valid = 1'b0;
    logic       req_grant = 1'b0;
    logic       hipri_req;
    int         n_chk = 0;
    int         n_fail = 0;

    always #2 clk = ~clk;

    req_escalate_timer dut_i (
        .clk(clk), .rst_n(rst_n), .thr_wr_en(thr_wr_en), .thr_wr_data(thr_wr_data),
        .thr_rd_data(thr_rd_data), .req_valid(req_valid), .req_grant(req_grant),
        .hipri_req(hipri_req)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_thr(input int v);
        thr_wr_en = 1'b1;
        thr_wr_data = 8'(v);
        step();
        thr_wr_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        @(negedge clk);
        step();
        step();
        rst_n = 1'b1;
        chk("R1 reset threshold", thr_rd_data, 8'h40);
        chk("R9 reset output", hipri_req, 0);

        // R2: default threshold 64 escalates exactly at edge 64
        req_valid = 1'b1;
        for (int k = 1; k <= 66; k++) begin
            step();
            chk("R2 default threshold", hipri_req, (k >= 64) ? 1 : 0);
        end
        req_valid = 1'b0;
        step();
        chk("R4 withdraw clears", hipri_req, 0);

        // R1 R2 R3: sweep every threshold value
        for (int t = 0; t < 256; t++) begin
            wr_thr(t);
            chk("R1 readback", thr_rd_data, t);
            req_valid = 1'b1;
            for (int k = 1; k <= ((t == 0) ? 20 : t + 2); k++) begin
                step();
                if (t == 0)
                    chk("R3 zero disables", hipri_req, 0);
                else if (k >= t - 1)
                    chk("R2 sweep", hipri_req, (k >= t) ? 1 : 0);
            end
            req_valid = 1'b0;
            step();
            chk("R9 idle low", hipri_req, 0);
        end

        // R4: a withdrawal restarts the timing
        wr_thr(10);
        req_valid = 1'b1;
        repeat (7) step();
        req_valid = 1'b0;
        step();
        req_valid = 1'b1;
        for (int k = 1; k <= 10; k++) begin
            step();
            if (k >= 9) chk("R4 restart after drop", hipri_req, (k >= 10) ? 1 : 0);
        end

        // R5: grant clears escalation and restarts count with request held
        wr_thr(5);
        req_valid = 1'b0;
        step();
        req_valid = 1'b1;
        repeat (6) step();
        chk("R5 escalated before grant", hipri_req, 1);
        req_grant = 1'b1;
        step();
        req_grant = 1'b0;
        chk("R5 grant clears", hipri_req, 0);
        for (int k = 1; k <= 5; k++) begin
            step();
            chk("R5 retime after grant", hipri_req, (k >= 5) ? 1 : 0);
        end
        req_valid = 1'b0;
        step();
        // R5: stray grant without request has no effect
        req_grant = 1'b1;
        step();
        req_grant = 1'b0;
        req_valid = 1'b1;
        for (int k = 1; k <= 5; k++) begin
            step();
            chk("R5 stray grant", hipri_req, (k >= 5) ? 1 : 0);
        end
        req_valid = 1'b0;
        step();

        // R7: lowering the threshold below elapsed wait escalates at once
        wr_thr(100);
        req_valid = 1'b1;
        repeat (30) step();
        chk("R7 before lower", hipri_req, 0);
        wr_thr(20);
        chk("R7 immediate escalation", hipri_req, 1);
        // R6: sticky through larger and zero thresholds
        wr_thr(200);
        chk("R6 sticky larger", hipri_req, 1);
        wr_thr(0);
        chk("R6 sticky zero", hipri_req, 1);
        repeat (5) step();
        chk("R6 sticky hold", hipri_req, 1);
        req_valid = 1'b0;
        step();
        chk("R9 drop after sticky", hipri_req, 0);

        // R7: lowering to a value still ahead escalates at that value
        wr_thr(100);
        req_valid = 1'b1;
        repeat (9) step();
        wr_thr(50);
        for (int k = 11; k <= 51; k++) begin
            step();
            if (k >= 49) chk("R7 lowered ahead", hipri_req, (k >= 50) ? 1 : 0);
        end
        req_valid = 1'b0;
        step();

        // R8: saturation at 255 keeps escalation for a long wait
        wr_thr(255);
        req_valid = 1'b1;
        for (int k = 1; k <= 300; k++) begin
            step();
            if (k >= 254) chk("R8 saturation", hipri_req, (k >= 255) ? 1 : 0);
        end
        req_valid = 1'b0;
        step();
        chk("R9 final idle", hipri_req, 0);
        finish_run();
    end
endmodule